// File: doc/BRIEF.md
# Translation context selector

This block sits in front of a two-stage radix translation unit. For every request it takes a 64-bit effective address, the hypervisor-state bit, the relocation flag, the access kind and the current partition and process identifier registers. It resolves the request into exactly one of three results: a translation context (the partition identifier and process identifier the table walker should use), a finished real address for hypervisor real-mode accesses, or a segment fault.

The address quadrant is taken from the two most significant effective-address bits. Which identifier registers feed the context depends on that quadrant and on whether the processor runs in hypervisor or guest state. A request with relocation off and hypervisor state bypasses all of this: the real address is built from the effective address and a real-mode offset register. Segment faults are sorted into an instruction class and a data class, and data-class faults capture the faulting address in a held fault-address register. Results appear one cycle after the request strobe, together with a single-cycle valid strobe.

Top module: `xlate_ctx_sel`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. When it is high, exactly one of `rsp_ctx_ok`, `rsp_real_ok` and `rsp_seg_fault` is set. Result fields that do not belong to that outcome (identifiers, real address, permission) read zero.
- R2: A relocated request, or any request in guest state, with any of effective-address bits 61 down to 52 set (bit 63 is the most significant) gives a segment fault.
- R3: In hypervisor state the quadrant `req_ea[63:62]` selects the context. Quadrant 0 gives partition 0 with the process register. Quadrant 1 gives both registers. Quadrant 2 gives the partition register with process 0. Quadrant 3 gives 0 for both.
- R4: In guest state, quadrant 0 gives both registers and quadrant 3 gives the partition register with process 0.
- R5: In guest state, quadrants 1 and 2 give a segment fault.
- R6: The access kind is coded 0 load, 1 store, 2 fetch. A segment fault on a fetch sets `rsp_iseg` and leaves `dar` unchanged. A segment fault on any other kind sets `rsp_dseg` and loads `dar` with the effective address.
- R7: With `req_reloc` low and `req_hv` high, `rsp_raddr` is the effective address with bits 63:60 cleared, ORed with `rmor_reg` when `req_ea[63]` is 0. `rsp_perm` is 3'b111 (read, write, execute).
- R8: A hypervisor real-mode request never faults, whatever its reserved bits or quadrant.
- R9: After reset, `rsp_valid`, all flags, all result fields and `dar` are zero.
- R10: Access code 3 behaves exactly as a load.
- R11: In cycles without a request, every result field and `dar` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 64 | Effective address |
| req_hv | input | 1 | Hypervisor state |
| req_reloc | input | 1 | Relocation enabled |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 as load |
| lpid_reg | input | LPID_W | Current partition identifier |
| pid_reg | input | PID_W | Current process identifier |
| rmor_reg | input | 64 | Real-mode offset |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_ctx_ok | output | 1 | Context resolved, ready for translation |
| rsp_real_ok | output | 1 | Real address formed directly |
| rsp_seg_fault | output | 1 | Segment fault |
| rsp_iseg | output | 1 | Fault is instruction class |
| rsp_dseg | output | 1 | Fault is data class |
| rsp_lpid | output | LPID_W | Selected partition identifier |
| rsp_pid | output | PID_W | Selected process identifier |
| rsp_raddr | output | 64 | Real address (real mode) |
| rsp_perm | output | 3 | Permission {read, write, execute} |
| dar | output | 64 | Captured data-fault address |

## Verification
The bench targets the quadrant table in both states. A swapped row would hand the walker the wrong identifier, for example a nonzero partition for hypervisor quadrant 0. Single reserved bits at each end of the 61:52 range are probed, so an off-by-one window either lets a bad address through or faults a good one. Real-mode requests are sent with reserved bits set, with the top bit both clear and set, and with offset bits overlapping the cleared nibble, which exposes a wrong offset condition or faults that leak into real mode. Fetch faults are placed between data faults, and access code 3 is driven, so a fault register that updates on fetches or ignores code 3 is seen at `dar`.

// File: rtl/xcs_pkg.sv
// Shared types for the translation context selector.
// Assumes access kinds are coded in two bits; code 3 is folded onto load.
package xcs_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    localparam logic [2:0] PERM_RWX  = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;

    // Outcome of the combinational stage.
    typedef enum logic [1:0] {
        OUT_CTX   = 2'd0,
        OUT_REAL  = 2'd1,
        OUT_FAULT = 2'd2
    } outcome_e;
endpackage

// File: rtl/xcs_quadrant_map.sv
// Maps a 2-bit address quadrant and the privilege state to a context.
// Assumes the identifier registers are already sampled by the caller.
// Produces ok=0 when the quadrant is illegal for the current state.
module xcs_quadrant_map #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [1:0]        quad,
    input  logic              hv,
    input  logic [LPID_W-1:0] lpid_in,
    input  logic [PID_W-1:0]  pid_in,
    output logic              ok,
    output logic [LPID_W-1:0] lpid_out,
    output logic [PID_W-1:0]  pid_out
);
    localparam logic [LPID_W-1:0] LPID_ZERO = '0;
    localparam logic [PID_W-1:0]  PID_ZERO  = '0;

    // Select identifiers per quadrant and state.
    always_comb begin
        ok       = 1'b1;
        lpid_out = LPID_ZERO;
        pid_out  = PID_ZERO;
        if (hv) begin
            unique case (quad)
                2'd0: pid_out = pid_in;
                2'd1: begin
                    lpid_out = lpid_in;
                    pid_out  = pid_in;
                end
                2'd2: lpid_out = lpid_in;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin
                    lpid_out = lpid_in;
                    pid_out  = pid_in;
                end
                2'd3: lpid_out = lpid_in;
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/xcs_realmode.sv
// Forms a hypervisor real-mode address from an effective address.
// Clears the top CLR_BITS bits and ORs in the offset register when the
// most significant address bit is zero.
module xcs_realmode #(
    parameter int EA_W     = 64,
    parameter int CLR_BITS = 4
) (
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] rmor,
    output logic [EA_W-1:0] raddr
);
    localparam int KEEP = EA_W - CLR_BITS;

    logic [EA_W-1:0] trimmed;

    // Drop the top nibble, then add the offset for the low half.
    always_comb begin
        trimmed = {{CLR_BITS{1'b0}}, ea[KEEP-1:0]};
        raddr   = ea[EA_W-1] ? trimmed : (trimmed | rmor);
    end
endmodule

// File: rtl/xcs_fault_class.sv
// Sorts a segment fault into instruction or data class from the access kind.
// Any code other than fetch is a data access.
module xcs_fault_class (
    input  xcs_pkg::acc_e acc,
    output logic          is_fetch,
    output logic          is_data
);
    // Decode access kind.
    always_comb begin
        is_fetch = (acc == xcs_pkg::ACC_FETCH);
        is_data  = !is_fetch;
    end
endmodule

// File: rtl/xlate_ctx_sel.sv
// Translation context selector: resolves one request per cycle into a
// context, a real-mode address or a segment fault, registered once.
// Assumes identifier and offset registers are stable with the request.
module xlate_ctx_sel #(
    parameter int EA_W      = 64,
    parameter int LPID_W    = 12,
    parameter int PID_W     = 20,
    parameter int QUAD_BITS = 2,
    parameter int RSV_BITS  = 10,
    parameter int CLR_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_hv,
    input  logic              req_reloc,
    input  logic [1:0]        req_acc,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [EA_W-1:0]   rmor_reg,
    output logic              rsp_valid,
    output logic              rsp_ctx_ok,
    output logic              rsp_real_ok,
    output logic              rsp_seg_fault,
    output logic              rsp_iseg,
    output logic              rsp_dseg,
    output logic [LPID_W-1:0] rsp_lpid,
    output logic [PID_W-1:0]  rsp_pid,
    output logic [EA_W-1:0]   rsp_raddr,
    output logic [2:0]        rsp_perm,
    output logic [EA_W-1:0]   dar
);
    import xcs_pkg::*;

    localparam int QUAD_HI = EA_W - 1;
    localparam int QUAD_LO = EA_W - QUAD_BITS;
    localparam int RSV_HI  = QUAD_LO - 1;
    localparam int RSV_LO  = QUAD_LO - RSV_BITS;

    logic              rsv_set;
    logic              real_mode;
    logic              map_ok;
    logic [LPID_W-1:0] map_lpid;
    logic [PID_W-1:0]  map_pid;
    logic [EA_W-1:0]   rm_addr;
    logic              cls_fetch;
    logic              cls_data;
    outcome_e          outcome;
    acc_e              acc;

    assign acc = acc_e'(req_acc);

    xcs_quadrant_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_map (
        .quad     (req_ea[QUAD_HI:QUAD_LO]),
        .hv       (req_hv),
        .lpid_in  (lpid_reg),
        .pid_in   (pid_reg),
        .ok       (map_ok),
        .lpid_out (map_lpid),
        .pid_out  (map_pid)
    );

    xcs_realmode #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_rm (
        .ea    (req_ea),
        .rmor  (rmor_reg),
        .raddr (rm_addr)
    );

    xcs_fault_class u_cls (
        .acc      (acc),
        .is_fetch (cls_fetch),
        .is_data  (cls_data)
    );

    // Decide the outcome of the current request.
    always_comb begin
        rsv_set   = |req_ea[RSV_HI:RSV_LO];
        real_mode = req_hv && !req_reloc;
        if (real_mode)
            outcome = OUT_REAL;
        else if (rsv_set || !map_ok)
            outcome = OUT_FAULT;
        else
            outcome = OUT_CTX;
    end

    // Register the result, pulse valid and capture data-fault addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_ctx_ok    <= 1'b0;
            rsp_real_ok   <= 1'b0;
            rsp_seg_fault <= 1'b0;
            rsp_iseg      <= 1'b0;
            rsp_dseg      <= 1'b0;
            rsp_lpid      <= '0;
            rsp_pid       <= '0;
            rsp_raddr     <= '0;
            rsp_perm      <= PERM_NONE;
            dar           <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ctx_ok    <= (outcome == OUT_CTX);
                rsp_real_ok   <= (outcome == OUT_REAL);
                rsp_seg_fault <= (outcome == OUT_FAULT);
                rsp_iseg      <= (outcome == OUT_FAULT) && cls_fetch;
                rsp_dseg      <= (outcome == OUT_FAULT) && cls_data;
                rsp_lpid      <= (outcome == OUT_CTX) ? map_lpid : '0;
                rsp_pid       <= (outcome == OUT_CTX) ? map_pid : '0;
                rsp_raddr     <= (outcome == OUT_REAL) ? rm_addr : '0;
                rsp_perm      <= (outcome == OUT_REAL) ? PERM_RWX : PERM_NONE;
                if (outcome == OUT_FAULT && cls_data)
                    dar <= req_ea;
            end
        end
    end
endmodule

// File: rtl/xcs_chk.sv
// Property checker for the translation context selector, bound to the top.
// Observes ports only; assumes the synchronous active-low reset.
module xcs_chk #(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [EA_W-1:0]   req_ea,
    input logic              req_hv,
    input logic              req_reloc,
    input logic              rsp_valid,
    input logic              rsp_ctx_ok,
    input logic              rsp_real_ok,
    input logic              rsp_seg_fault,
    input logic              rsp_iseg,
    input logic              rsp_dseg,
    input logic [LPID_W-1:0] rsp_lpid,
    input logic [PID_W-1:0]  rsp_pid,
    input logic [EA_W-1:0]   rsp_raddr,
    input logic [2:0]        rsp_perm,
    input logic [EA_W-1:0]   dar
);
    // R1
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R1
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_ctx_ok, rsp_real_ok, rsp_seg_fault}) == 1);
    // R5
    guest_bad_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hv && (req_ea[EA_W-1] != req_ea[EA_W-2])) |=> rsp_seg_fault);
    // R6
    fault_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_seg_fault) |-> $onehot({rsp_iseg, rsp_dseg}));
    // R6
    fetch_keeps_dar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_iseg) |-> $stable(dar));
    // R7
    real_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_real_ok) |-> (rsp_perm == 3'b111 && rsp_lpid == '0 && rsp_pid == '0));
    // R8
    real_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hv && !req_reloc) |=> rsp_real_ok);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_raddr) && $stable(dar) && $stable(rsp_lpid) && $stable(rsp_pid)));
endmodule

bind xlate_ctx_sel xcs_chk #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_xcs_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ea        (req_ea),
    .req_hv        (req_hv),
    .req_reloc     (req_reloc),
    .rsp_valid     (rsp_valid),
    .rsp_ctx_ok    (rsp_ctx_ok),
    .rsp_real_ok   (rsp_real_ok),
    .rsp_seg_fault (rsp_seg_fault),
    .rsp_iseg      (rsp_iseg),
    .rsp_dseg      (rsp_dseg),
    .rsp_lpid      (rsp_lpid),
    .rsp_pid       (rsp_pid),
    .rsp_raddr     (rsp_raddr),
    .rsp_perm      (rsp_perm),
    .dar           (dar)
);

// File: tb/tb_xlate_ctx_sel.sv
// Self-checking bench: directed corners plus seeded random requests,
// compared against a model written from the requirements.
module tb_xlate_ctx_sel;
    localparam int LPID_W = 12;
    localparam int PID_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [63:0]       req_ea = '0;
    logic              req_hv = 1'b0;
    logic              req_reloc = 1'b0;
    logic [1:0]        req_acc = '0;
    logic [LPID_W-1:0] lpid_reg = '0;
    logic [PID_W-1:0]  pid_reg = '0;
    logic [63:0]       rmor_reg = '0;
    logic              rsp_valid, rsp_ctx_ok, rsp_real_ok, rsp_seg_fault, rsp_iseg, rsp_dseg;
    logic [LPID_W-1:0] rsp_lpid;
    logic [PID_W-1:0]  rsp_pid;
    logic [63:0]       rsp_raddr;
    logic [2:0]        rsp_perm;
    logic [63:0]       dar;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_dar = '0;

    always #10 clk = ~clk;

    xlate_ctx_sel #(.LPID_W(LPID_W), .PID_W(PID_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_hv(req_hv), .req_reloc(req_reloc), .req_acc(req_acc),
        .lpid_reg(lpid_reg), .pid_reg(pid_reg), .rmor_reg(rmor_reg),
        .rsp_valid(rsp_valid), .rsp_ctx_ok(rsp_ctx_ok), .rsp_real_ok(rsp_real_ok),
        .rsp_seg_fault(rsp_seg_fault), .rsp_iseg(rsp_iseg), .rsp_dseg(rsp_dseg),
        .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid), .rsp_raddr(rsp_raddr),
        .rsp_perm(rsp_perm), .dar(dar)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Model: flags {valid,ctx,real,fault,iseg,dseg}, ids, raddr, perm.
    task automatic model(input logic [63:0] ea, input logic hv, input logic rl,
                         input logic [1:0] acc, output logic [5:0] fl,
                         output logic [LPID_W-1:0] lp, output logic [PID_W-1:0] pd,
                         output logic [63:0] ra, output logic [2:0] pm, output string tag);
        logic [1:0] q = ea[63:62];
        logic bad = 1'b0;
        lp = '0; pd = '0; ra = '0; pm = 3'b000;
        if (hv && !rl) begin
            ra = {4'h0, ea[59:0]};
            if (!ea[63]) ra = ra | rmor_reg;
            pm = 3'b111;
            fl = 6'b101000;
            tag = "R7/R8";
            return;
        end
        if (ea[61:52] != 0) bad = 1'b1;
        if (hv) begin
            tag = "R3";
            if (q == 2'd0) pd = pid_reg;
            if (q == 2'd1) begin lp = lpid_reg; pd = pid_reg; end
            if (q == 2'd2) lp = lpid_reg;
        end else begin
            tag = "R4";
            if (q == 2'd0) begin lp = lpid_reg; pd = pid_reg; end
            else if (q == 2'd3) lp = lpid_reg;
            else begin bad = 1'b1; tag = "R5"; end
        end
        if (bad) begin
            if (ea[61:52] != 0) tag = "R2";
            lp = '0; pd = '0;
            if (acc == 2'd2) fl = 6'b100110;
            else begin fl = 6'b100101; exp_dar = ea; end
        end else begin
            fl = 6'b110000;
        end
    endtask

    task automatic req(input logic [63:0] ea, input logic hv, input logic rl, input logic [1:0] acc);
        logic [5:0] fl;
        logic [LPID_W-1:0] lp;
        logic [PID_W-1:0] pd;
        logic [63:0] ra;
        logic [2:0] pm;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_hv = hv; req_reloc = rl; req_acc = acc;
        model(ea, hv, rl, acc, fl, lp, pd, ra, pm, tag);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R1 R6 flags"}, 64'({rsp_valid, rsp_ctx_ok, rsp_real_ok, rsp_seg_fault, rsp_iseg, rsp_dseg}), 64'(fl));
        check({tag, " ids"}, 64'({rsp_lpid, rsp_pid}), 64'({lp, pd}));
        check({tag, " raddr"}, rsp_raddr, ra);
        check({tag, " perm"}, 64'(rsp_perm), 64'(pm));
        check({tag, " R6 dar"}, dar, exp_dar);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] hold_ra;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset flags", 64'({rsp_valid, rsp_ctx_ok, rsp_real_ok, rsp_seg_fault, rsp_iseg, rsp_dseg}), 64'd0);
        check("R9 reset dar", dar, 64'd0);
        check("R9 reset raddr", rsp_raddr, 64'd0);
        rst_n = 1'b1;
        lpid_reg = 12'hA5C; pid_reg = 20'h1_2345; rmor_reg = 64'hF000_0000_0400_0000;
        // R3: each hypervisor quadrant
        for (int q = 0; q < 4; q++) req({q[1:0], 62'h1234}, 1'b1, 1'b1, 2'd0);
        // R4, R5: each guest quadrant, fetch and store
        for (int q = 0; q < 4; q++) req({q[1:0], 62'h0BEE}, 1'b0, 1'b1, 2'd1);
        for (int q = 0; q < 4; q++) req({q[1:0], 62'h0CAF}, 1'b0, 1'b1, 2'd2);
        // R2: reserved bit at each end of the range
        req(64'h0010_0000_0000_0000, 1'b1, 1'b1, 2'd0);
        req(64'h2000_0000_0000_0000, 1'b1, 1'b1, 2'd1);
        req(64'h000F_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'd0);
        // R2: guest real mode still faults on reserved bits
        req(64'h0040_0000_0000_0001, 1'b0, 1'b0, 2'd0);
        // R6: fetch fault keeps the captured data address
        req(64'h3000_0000_0000_0777, 1'b1, 1'b1, 2'd2);
        // R10: code 3 acts as load
        req(64'h4000_0000_0000_0999, 1'b0, 1'b1, 2'd3);
        req(64'h0000_0000_0000_0abc, 1'b0, 1'b1, 2'd3);
        // R7, R8: real mode with reserved bits, both top-bit values
        req(64'h7FFF_0000_1111_2222, 1'b1, 1'b0, 2'd2);
        req(64'hBFFF_0000_1111_2222, 1'b1, 1'b0, 2'd0);
        // R11: idle cycles hold results
        hold_ra = rsp_raddr;
        req_ea = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R11 hold raddr", rsp_raddr, hold_ra);
        check("R11 hold dar", dar, exp_dar);
        check("R11 no valid", 64'(rsp_valid), 64'd0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ea = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) ea[61:52] = '0;
            lpid_reg = LPID_W'($urandom);
            pid_reg  = PID_W'($urandom);
            rmor_reg = {$urandom, $urandom};
            req(ea, 1'($urandom), 1'($urandom_range(0, 3) != 0), 2'($urandom));
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule